// File: doc/BRIEF.md
# Position-Priority Shared Bus Arbiter

This block decides which of several devices owns a shared bus, without any central arbiter. Each device holds one small arbitration cell. The cells sit in a chain, and a single arbitration signal enters the head of that chain and passes from cell to cell. Two more shared lines complete the scheme. The first is a request line, formed as the OR of every device's request. The second is a busy line, which is high while some device owns the bus. The wiring stays at these three lines however many devices are attached.

A cell that wants the bus cuts the arbitration signal, so that every cell further down the chain sees it low. A cell wins the bus only when two conditions hold in the same cycle: the busy line is low and its own chain input is high. After winning, the cell asserts its grant and drives the busy line. It keeps the bus until its release input is pulsed. Because of the cut, the requesting cell nearest the head of the chain always wins. The wrapper chains the parameterised number of cells, holds the head of the chain high, and forms both shared lines from the cells' outputs.

Top module: `daisy_bus_arbiter`

## Requirements
- R1: While reset is high, and in the first cycle after reset, all grant bits and the busy line are 0.
- R2: When no device is requesting and the bus is not busy, the arbitration signal passes through the whole chain, so `chain_tail` is 1.
- R3: If `dev_req[i]` is 1 on a rising edge, the busy line is low and no requesting device has a lower index, then `dev_grant[i]` is 1 after that edge.
- R4: When several devices request at once while the bus is idle, the device with the lowest index is granted. Index 0 is at the head of the chain.
- R5: While the bus is idle and any device is requesting, that device cuts the chain, so `chain_tail` is 0.
- R6: `bus_busy` is 1 exactly when some grant bit is 1.
- R7: While the bus is owned, requests from other devices have no effect, including requests from devices with a lower index. The grant vector stays unchanged.
- R8: A pulse on `dev_rel[i]` while device i owns the bus clears its grant and the busy line on the next edge. A new owner can be granted on the edge after that.
- R9: A release pulse from a device that does not own the bus has no effect on the grants.
- R10: At most one grant bit is 1 at any time.
- R11: `bus_request` is the OR of all `dev_req` bits.
- R12: An owner keeps its grant after dropping its own request, until it releases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dev_req | input | NUM_DEV | Per-device request, bit 0 at the chain head |
| dev_rel | input | NUM_DEV | Per-device release pulse, acted on only by the owner |
| dev_grant | output | NUM_DEV | Per-device ownership flag |
| bus_busy | output | 1 | Shared busy line, OR of the owners' drives |
| bus_request | output | 1 | Shared request line, OR of the requests |
| chain_tail | output | 1 | Arbitration signal leaving the last cell |

## Verification
The assertions assume that the request and release inputs are stable around each rising edge. They also assume that release pulses and requests may arrive in any pattern, with no ordering promised between them. Several properties compare the grant vector across a single edge. To keep those comparisons sound, the stimulus changes inputs only on falling edges and holds each release high for exactly one cycle. The bench also drives releases at devices that do not own the bus, and requests while the bus is owned. Both are legal inputs that the assertions must tolerate.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic {
        CELL_IDLE   = 1'b0,
        CELL_MASTER = 1'b1
    } cell_state_e;

    localparam logic CHAIN_HEAD_LEVEL = 1'b1;

    function automatic cell_state_e cell_next(
        input cell_state_e cur,
        input logic        want,
        input logic        drop,
        input logic        link_in,
        input logic        busy
    );
        cell_state_e nxt;
        nxt = cur;
        case (cur)
            CELL_IDLE:   if (want && link_in && !busy) nxt = CELL_MASTER;
            CELL_MASTER: if (drop) nxt = CELL_IDLE;
            default:     nxt = CELL_IDLE;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/arb_wired_or.sv
module arb_wired_or #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] drivers,
    output logic             line
);
    assign line = |drivers;
endmodule

// File: rtl/arb_cell.sv
module arb_cell
    import arb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic local_req,
    input  logic local_rel,
    input  logic link_in,
    input  logic busy_in,
    output logic grant,
    output logic link_out,
    output logic busy_drv
);
    cell_state_e state_q;
    logic        owner;
    logic        contend;

    always_ff @(posedge clk) begin
        if (rst) state_q <= CELL_IDLE;
        else     state_q <= cell_next(state_q, local_req, local_rel, link_in, busy_in);
    end

    assign owner    = (state_q == CELL_MASTER);
    assign contend  = local_req & ~busy_in & ~owner;
    assign link_out = link_in & ~contend & ~owner;
    assign grant    = owner;
    assign busy_drv = owner;
endmodule

// File: rtl/daisy_bus_arbiter.sv
module daisy_bus_arbiter
    import arb_pkg::*;
#(
    parameter int NUM_DEV = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_DEV-1:0] dev_req,
    input  logic [NUM_DEV-1:0] dev_rel,
    output logic [NUM_DEV-1:0] dev_grant,
    output logic               bus_busy,
    output logic               bus_request,
    output logic               chain_tail
);
    localparam int LINKS = NUM_DEV + 1;

    logic [LINKS-1:0]   link;
    logic [NUM_DEV-1:0] busy_drv;

    assign link[0] = CHAIN_HEAD_LEVEL;

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_cell
        arb_cell u_cell (
            .clk       (clk),
            .rst       (rst),
            .local_req (dev_req[g]),
            .local_rel (dev_rel[g]),
            .link_in   (link[g]),
            .busy_in   (bus_busy),
            .grant     (dev_grant[g]),
            .link_out  (link[g+1]),
            .busy_drv  (busy_drv[g])
        );
    end

    arb_wired_or #(.WIDTH(NUM_DEV)) u_busy_line (
        .drivers (busy_drv),
        .line    (bus_busy)
    );

    arb_wired_or #(.WIDTH(NUM_DEV)) u_req_line (
        .drivers (dev_req),
        .line    (bus_request)
    );

    assign chain_tail = link[NUM_DEV];
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
    parameter int NUM_DEV = 4
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_DEV-1:0] dev_req,
    input logic [NUM_DEV-1:0] dev_rel,
    input logic [NUM_DEV-1:0] dev_grant,
    input logic               bus_busy
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (dev_grant == '0));

    assert_busy_matches_R6: assert property (@(posedge clk) disable iff (rst)
        bus_busy == (|dev_grant));

    assert_one_owner_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dev_grant));

    assert_idle_grants_R3: assert property (@(posedge clk) disable iff (rst)
        (!bus_busy && (|dev_req)) |=> (|dev_grant));

    assert_head_wins_R4: assert property (@(posedge clk) disable iff (rst)
        (!bus_busy && dev_req[0]) |=> dev_grant[0]);

    assert_hold_while_owned_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_busy && !(|(dev_grant & dev_rel))) |=> $stable(dev_grant));

    assert_release_frees_R8: assert property (@(posedge clk) disable iff (rst)
        (|(dev_grant & dev_rel)) |=> !bus_busy);
endmodule

bind daisy_bus_arbiter arb_checker #(.NUM_DEV(NUM_DEV)) u_arb_checker (
    .clk       (clk),
    .rst       (rst),
    .dev_req   (dev_req),
    .dev_rel   (dev_rel),
    .dev_grant (dev_grant),
    .bus_busy  (bus_busy)
);

// File: tb/test_daisy_bus_arbiter.sv
module test_daisy_bus_arbiter;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] dev_req;
    logic [N-1:0] dev_rel;
    logic [N-1:0] dev_grant;
    logic         bus_busy;
    logic         bus_request;
    logic         chain_tail;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    daisy_bus_arbiter #(.NUM_DEV(N)) i_daisy_bus_arbiter (
        .clk         (clk),
        .rst         (rst),
        .dev_req     (dev_req),
        .dev_rel     (dev_rel),
        .dev_grant   (dev_grant),
        .bus_busy    (bus_busy),
        .bus_request (bus_request),
        .chain_tail  (chain_tail)
    );

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, actual, expected);
        end
    endtask

    // drive inputs on the falling edge, then let them settle
    task automatic drive(input logic [N-1:0] r, input logic [N-1:0] l);
        @(negedge clk);
        dev_req = r;
        dev_rel = l;
        #1;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        dev_req = '1;
        dev_rel = '0;
        repeat (2) tick();
        check("R1 grant in reset", int'(dev_grant), 0);
        check("R1 busy in reset", int'(bus_busy), 0);
        drive('0, '0);
        rst = 1'b0;
        tick();
        check("R1 grant after reset", int'(dev_grant), 0);
    endtask

    task automatic t_idle_chain();
        drive('0, '0);
        check("R2 chain passes", int'(chain_tail), 1);
        check("R11 request low", int'(bus_request), 0);
        tick();
        check("R2 no grant", int'(dev_grant), 0);
    endtask

    task automatic t_single();
        drive(4'b0100, '0);
        check("R5 chain cut", int'(chain_tail), 0);
        check("R11 request high", int'(bus_request), 1);
        tick();
        check("R3 grant dev2", int'(dev_grant), 4'b0100);
        check("R6 busy on", int'(bus_busy), 1);
        drive('0, '0);
        tick();
        check("R12 grant held", int'(dev_grant), 4'b0100);
        drive('0, 4'b0100);
        tick();
        check("R8 grant cleared", int'(dev_grant), 0);
        check("R8 busy cleared", int'(bus_busy), 0);
        drive('0, '0);
        check("R2 chain restored", int'(chain_tail), 1);
    endtask

    task automatic t_priority();
        drive(4'b1010, '0);
        tick();
        check("R4 lowest index wins", int'(dev_grant), 4'b0010);
        drive(4'b1000, 4'b0010);
        tick();
        check("R8 release edge", int'(dev_grant), 0);
        drive(4'b1000, '0);
        tick();
        check("R8 next owner", int'(dev_grant), 4'b1000);
    endtask

    task automatic t_ignore_busy();
        drive(4'b1001, '0);
        tick();
        check("R7 head request ignored", int'(dev_grant), 4'b1000);
        drive(4'b1000, 4'b0010);
        tick();
        check("R9 foreign release ignored", int'(dev_grant), 4'b1000);
        check("R9 busy kept", int'(bus_busy), 1);
        drive('0, 4'b1000);
        tick();
        check("R8 dev3 released", int'(dev_grant), 0);
    endtask

    task automatic t_all();
        drive('1, '0);
        tick();
        check("R4 all request", int'(dev_grant), 4'b0001);
        check("R10 single grant", $countones(dev_grant), 1);
        drive('0, 4'b0001);
        tick();
        check("R8 final release", int'(bus_busy), 0);
        drive('0, '0);
    endtask

    initial begin
        t_reset();
        t_idle_chain();
        t_single();
        t_priority();
        t_ignore_busy();
        t_all();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #2_000_000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule